// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block takes a small set of interrupt request lines and decides whether a processor should be interrupted, and by which line. Each line has a request bit, an in-service bit, a mask bit and a trigger-mode bit that selects edge or level. Requests pass through a two-flop synchronizer before they are captured. The block picks the highest-priority unmasked request and raises `int_out` only when that request outranks every line already being serviced.

Priority is not fixed. A rotation base names the line that currently ranks highest, and the other lines follow it in ascending order, wrapping round. An acknowledge pulse marks a line as in service, unless automatic end-of-interrupt is enabled. In that mode the acknowledge can instead move the rotation base to the line after the acknowledged one. An end-of-interrupt pulse clears one named in-service bit. Two comparison options exist. Special mask drops masked lines from the in-service comparison. Special nested mode, on a master, ignores the in-service bit of the cascade line.

Configuration arrives on plain load ports, each with a write strobe. Host bus decoding and cascading are outside the block.

Top module: `prio_irq_resolver`

## Requirements
- R1: After reset, `int_out` is 0, and the request bits, in-service bits, mask bits and rotation base are all 0.
- R2: Priority position p (0 is the highest) belongs to line (p + rotation base) mod 8. `irq_vec` names the line at the lowest position that is set in (request AND NOT mask).
- R3: A line whose mask bit is 1 is never selected. With every request set, `int_out` is 0 exactly when the mask is all ones.
- R4: For an edge line (trigger bit 0), the request bit is set by a rising synchronized input and stays set after the input falls. For a level line (trigger bit 1), the request bit follows the synchronized input. An input change shows in `req_out` three clock edges later.
- R5: An acknowledge without auto-EOI sets the acknowledged line's in-service bit. It clears that line's request bit only when the line is an edge line; the request bit of a level line is left alone.
- R6: `int_out` is 1 only when the candidate's position is strictly lower than the position of the highest-priority in-service bit.
- R7: With special mask on, in-service bits of masked lines are left out of the R6 comparison.
- R8: With special nested mode on and `is_master` set to 1, in-service bit 2 is left out of the R6 comparison. If either of the two is 0, bit 2 counts.
- R9: An acknowledge with auto-EOI sets no in-service bit. If rotate-on-auto-EOI is also on, the rotation base becomes (line + 1) mod 8, and this takes precedence over a rotation load in the same cycle.
- R10: An end-of-interrupt pulse clears the named in-service bit. An acknowledge of the same line in the same cycle wins, and the bit stays set.
- R11: When a new rising edge on an edge line and an acknowledge of that line fall in the same cycle, the request bit ends up set.
- R12: Reset leaves every line in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Raw interrupt request lines |
| mask_wr | input | 1 | Load strobe for the mask |
| mask_val | input | 8 | New mask value (1 = masked) |
| trig_wr | input | 1 | Load strobe for the trigger select |
| trig_val | input | 8 | New trigger select (1 = level, 0 = edge) |
| rot_wr | input | 1 | Load strobe for the rotation base |
| rot_val | input | 3 | New rotation base |
| aeoi_en | input | 1 | Auto-EOI enable |
| aeoi_rot | input | 1 | Rotate on auto-EOI |
| smask_en | input | 1 | Special mask enable |
| sfn_en | input | 1 | Special nested mode enable |
| is_master | input | 1 | Marks this instance as the master |
| ack_valid | input | 1 | Acknowledge pulse |
| ack_line | input | 3 | Line that is acknowledged |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_line | input | 3 | Line whose in-service bit is cleared |
| int_out | output | 1 | Interrupt output |
| irq_vec | output | 3 | Line selected as the candidate |
| req_out | output | 8 | Request bits |
| isr_out | output | 8 | In-service bits |
| rot_out | output | 3 | Rotation base |

## Verification
An acknowledge can fall in the same cycle as a fresh rising edge on the same edge line. The clear from the acknowledge and the set from the edge then compete, and the set must win. The bench provokes this by timing the acknowledge to the clock edge where the synchronized edge is captured, then checks that the request bit is still set. It also pairs an acknowledge with an end-of-interrupt on the same line and checks that the in-service bit stays set.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
    localparam int unsigned IRQR_LINES    = 8;
    localparam int unsigned IRQR_SYNC     = 2;
    localparam int unsigned IRQR_CASCADE  = 2;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;
endpackage

// File: rtl/irqr_sync.sv
module irqr_sync #(
    parameter int unsigned N      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] synced
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], raw[i]};
        end
        assign synced[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/irqr_prio_search.sv
module irqr_prio_search #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = $clog2(N),
    parameter int unsigned PW    = IDX_W + 1
) (
    input  logic [N-1:0]     vec,
    input  logic [IDX_W-1:0] base,
    output logic [PW-1:0]    pos
);
    always_comb begin
        int ln;
        logic [IDX_W-1:0] lb;
        pos = PW'(N);
        for (int p = N - 1; p >= 0; p--) begin
            ln = (p + int'(base)) % N;
            lb = IDX_W'(ln);
            if (vec[lb]) pos = PW'(p);
        end
    end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
    import irqr_pkg::*;
#(
    parameter int unsigned N        = IRQR_LINES,
    parameter int unsigned STAGES   = IRQR_SYNC,
    parameter int unsigned CASCADE  = IRQR_CASCADE,
    localparam int unsigned IDX_W   = $clog2(N),
    localparam int unsigned PW      = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_in,
    input  logic             mask_wr,
    input  logic [N-1:0]     mask_val,
    input  logic             trig_wr,
    input  logic [N-1:0]     trig_val,
    input  logic             rot_wr,
    input  logic [IDX_W-1:0] rot_val,
    input  logic             aeoi_en,
    input  logic             aeoi_rot,
    input  logic             smask_en,
    input  logic             sfn_en,
    input  logic             is_master,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_line,
    input  logic             eoi_valid,
    input  logic [IDX_W-1:0] eoi_line,
    output logic             int_out,
    output logic [IDX_W-1:0] irq_vec,
    output logic [N-1:0]     req_out,
    output logic [N-1:0]     isr_out,
    output logic [IDX_W-1:0] rot_out
);
    typedef struct packed {
        logic [N-1:0]     req;
        logic [N-1:0]     last;
        logic [N-1:0]     mask;
        logic [N-1:0]     trig;
        logic [N-1:0]     isr;
        logic [IDX_W-1:0] rot;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]  lvl_sync;
    logic [N-1:0]  cand_vec;
    logic [N-1:0]  busy_vec;
    logic [PW-1:0] cand_pos;
    logic [PW-1:0] busy_pos;
    logic [N-1:0]  mask_q;

    irqr_sync #(.N(N), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (irq_in),
        .synced (lvl_sync)
    );

    irqr_prio_search #(.N(N)) u_cand (
        .vec  (cand_vec),
        .base (st_q.rot),
        .pos  (cand_pos)
    );

    irqr_prio_search #(.N(N)) u_busy (
        .vec  (busy_vec),
        .base (st_q.rot),
        .pos  (busy_pos)
    );

    // comparison sets
    always_comb begin
        cand_vec = st_q.req & ~st_q.mask;
        busy_vec = st_q.isr;
        if (smask_en) busy_vec = busy_vec & ~st_q.mask;
        if (sfn_en && is_master) busy_vec[CASCADE] = 1'b0;
    end

    // next-state computation
    always_comb begin
        logic [N-1:0] rise;
        st_d      = st_q;
        rise      = lvl_sync & ~st_q.last;
        st_d.last = lvl_sync;

        if (mask_wr) st_d.mask = mask_val;
        if (trig_wr) st_d.trig = trig_val;
        if (rot_wr)  st_d.rot  = rot_val;

        if (ack_valid && (st_q.trig[ack_line] == TRIG_EDGE))
            st_d.req[ack_line] = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (st_q.trig[i] == TRIG_LEVEL) st_d.req[i] = lvl_sync[i];
            else if (rise[i])               st_d.req[i] = 1'b1;
        end

        if (eoi_valid) st_d.isr[eoi_line] = 1'b0;
        if (ack_valid) begin
            if (aeoi_en) begin
                if (aeoi_rot) st_d.rot = ack_line + IDX_W'(1);
            end else begin
                st_d.isr[ack_line] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        int sum;
        sum     = int'(cand_pos[IDX_W-1:0]) + int'(st_q.rot);
        irq_vec = IDX_W'(sum % N);
        int_out = (cand_pos < busy_pos);
    end

    assign req_out = st_q.req;
    assign isr_out = st_q.isr;
    assign rot_out = st_q.rot;
    assign mask_q  = st_q.mask;
endmodule

// File: rtl/irqr_checker.sv
module irqr_checker #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             aeoi_en,
    input logic             aeoi_rot,
    input logic             ack_valid,
    input logic [IDX_W-1:0] ack_line,
    input logic             eoi_valid,
    input logic [IDX_W-1:0] eoi_line,
    input logic             int_out,
    input logic [IDX_W-1:0] irq_vec,
    input logic [N-1:0]     req_out,
    input logic [N-1:0]     isr_out,
    input logic [IDX_W-1:0] rot_out,
    input logic [N-1:0]     mask_q
);
    logic [IDX_W-1:0] ack_next;
    assign ack_next = ack_line + IDX_W'(1);

    assert_ack_sets_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !aeoi_en) |=> isr_out[$past(ack_line)]);

    assert_aeoi_rotates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && aeoi_en && aeoi_rot) |=> (rot_out == $past(ack_next)));

    assert_eoi_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !(ack_valid && !aeoi_en && ack_line == eoi_line))
        |=> !isr_out[$past(eoi_line)]);

    assert_int_has_cand_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((req_out & ~mask_q) != '0));

    assert_vec_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (req_out[irq_vec] && !mask_q[irq_vec]));
endmodule

bind prio_irq_resolver irqr_checker #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .aeoi_en   (aeoi_en),
    .aeoi_rot  (aeoi_rot),
    .ack_valid (ack_valid),
    .ack_line  (ack_line),
    .eoi_valid (eoi_valid),
    .eoi_line  (eoi_line),
    .int_out   (int_out),
    .irq_vec   (irq_vec),
    .req_out   (req_out),
    .isr_out   (isr_out),
    .rot_out   (rot_out),
    .mask_q    (mask_q)
);

// File: tb/prio_irq_resolver_bench.sv
`timescale 1ns/1ps
module prio_irq_resolver_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       mask_wr = 0, trig_wr = 0, rot_wr = 0;
    logic [7:0] mask_val = '0, trig_val = '0;
    logic [2:0] rot_val = '0;
    logic       aeoi_en = 0, aeoi_rot = 0, smask_en = 0, sfn_en = 0, is_master = 0;
    logic       ack_valid = 0, eoi_valid = 0;
    logic [2:0] ack_line = '0, eoi_line = '0;
    logic       int_out;
    logic [2:0] irq_vec, rot_out;
    logic [7:0] req_out, isr_out;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    prio_irq_resolver u_prio_irq_resolver (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .mask_wr(mask_wr), .mask_val(mask_val),
        .trig_wr(trig_wr), .trig_val(trig_val),
        .rot_wr(rot_wr), .rot_val(rot_val),
        .aeoi_en(aeoi_en), .aeoi_rot(aeoi_rot), .smask_en(smask_en),
        .sfn_en(sfn_en), .is_master(is_master),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .eoi_valid(eoi_valid), .eoi_line(eoi_line),
        .int_out(int_out), .irq_vec(irq_vec), .req_out(req_out),
        .isr_out(isr_out), .rot_out(rot_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_pos(input logic [7:0] v, input int rot);
        for (int p = 0; p < 8; p++) if (v[(p + rot) % 8]) return p;
        return 8;
    endfunction

    task automatic do_reset();
        rst_n = 0;
        irq_in = '0; aeoi_en = 0; aeoi_rot = 0; smask_en = 0; sfn_en = 0; is_master = 0;
        ack_valid = 0; eoi_valid = 0; mask_wr = 0; trig_wr = 0; rot_wr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_mask(input logic [7:0] v);
        mask_val = v; mask_wr = 1; @(negedge clk); mask_wr = 0;
    endtask
    task automatic load_trig(input logic [7:0] v);
        trig_val = v; trig_wr = 1; @(negedge clk); trig_wr = 0;
    endtask
    task automatic load_rot(input logic [2:0] v);
        rot_val = v; rot_wr = 1; @(negedge clk); rot_wr = 0;
    endtask
    task automatic ack(input logic [2:0] l);
        ack_line = l; ack_valid = 1; @(negedge clk); ack_valid = 0;
    endtask
    task automatic eoi(input logic [2:0] l);
        eoi_line = l; eoi_valid = 1; @(negedge clk); eoi_valid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(int_out == 0, "R1 int_out", int_out, 0);
        chk(req_out == 0 && isr_out == 0, "R1 req/isr", {req_out, isr_out}, 0);
        chk(rot_out == 0, "R1 rot", rot_out, 0);

        // R12: all lines edge after reset: pulse line 6 and drop it
        irq_in = 8'h40; settle();
        irq_in = 8'h00; settle();
        chk(req_out == 8'h40, "R12 edge default holds", req_out, 8'h40);

        // R2 sweep rotation x request pattern with level lines
        do_reset();
        load_trig(8'hFF);
        for (int r = 0; r < 8; r++) begin
            load_rot(3'(r));
            for (int v = 0; v < 256; v++) begin
                int ep;
                irq_in = 8'(v);
                settle();
                ep = exp_pos(8'(v), r);
                chk(int_out == (ep < 8), "R2 int", int_out, (ep < 8));
                if (ep < 8)
                    chk(irq_vec == 3'((ep + r) % 8), "R2 vec", irq_vec, (ep + r) % 8);
            end
        end

        // R3 mask sweep, all requests set, rotation 3
        load_rot(3'd3);
        irq_in = 8'hFF; settle();
        for (int m = 0; m < 256; m++) begin
            int ep;
            load_mask(8'(m));
            ep = exp_pos(~8'(m), 3);
            chk(int_out == (m != 255), "R3 int", int_out, (m != 255));
            if (ep < 8)
                chk(irq_vec == 3'((ep + 3) % 8), "R3 vec", irq_vec, (ep + 3) % 8);
        end

        // R4 edge and level capture
        do_reset();
        load_trig(8'h01);             // line 0 level, line 4 edge
        irq_in = 8'h11;
        repeat (2) @(posedge clk); @(negedge clk);
        chk(req_out == 8'h00, "R4 not yet after two edges", req_out, 0);
        @(posedge clk); @(negedge clk);
        chk(req_out == 8'h11, "R4 after three edges", req_out, 8'h11);
        irq_in = 8'h00; settle();
        chk(req_out == 8'h10, "R4 level follows, edge holds", req_out, 8'h10);

        // R5 ack without auto-EOI
        irq_in = 8'h01; settle();
        ack(3'd4);
        chk(isr_out == 8'h10, "R5 isr set", isr_out, 8'h10);
        chk(req_out == 8'h01, "R5 edge req cleared", req_out, 8'h01);
        ack(3'd0);
        chk(isr_out == 8'h11, "R5 isr set level", isr_out, 8'h11);
        chk(req_out == 8'h01, "R5 level req kept", req_out, 8'h01);

        // R10 eoi clears, and ack wins on same line
        eoi(3'd4);
        chk(isr_out == 8'h01, "R10 eoi clear", isr_out, 8'h01);
        ack_line = 3'd5; eoi_line = 3'd5; ack_valid = 1; eoi_valid = 1;
        @(negedge clk); ack_valid = 0; eoi_valid = 0;
        chk(isr_out == 8'h21, "R10 ack beats eoi", isr_out, 8'h21);

        // R6 comparison against in-service
        do_reset();
        load_trig(8'hFF);
        ack(3'd3);
        irq_in = 8'h02; settle();
        chk(int_out == 1 && irq_vec == 1, "R6 higher fires", {int_out, irq_vec}, 4'h9);
        irq_in = 8'h08; settle();
        chk(int_out == 0, "R6 equal blocked", int_out, 0);
        irq_in = 8'h40; settle();
        chk(int_out == 0, "R6 lower blocked", int_out, 0);
        load_rot(3'd5);               // order 5,6,7,0..: 6 now outranks 3
        chk(int_out == 1 && irq_vec == 6, "R6 rotated fires", {int_out, irq_vec}, 4'hE);

        // R7 special mask
        do_reset();
        load_trig(8'hFF);
        ack(3'd1);
        load_mask(8'h02);
        irq_in = 8'h20; settle();
        chk(int_out == 0, "R7 off blocks", int_out, 0);
        smask_en = 1; @(negedge clk);
        chk(int_out == 1 && irq_vec == 5, "R7 on fires", {int_out, irq_vec}, 4'hD);

        // R8 special nested on master
        do_reset();
        load_trig(8'hFF);
        ack(3'd2);
        irq_in = 8'h04; settle();
        chk(int_out == 0, "R8 off blocks", int_out, 0);
        sfn_en = 1; @(negedge clk);
        chk(int_out == 0, "R8 not master blocks", int_out, 0);
        is_master = 1; @(negedge clk);
        chk(int_out == 1 && irq_vec == 2, "R8 master fires", {int_out, irq_vec}, 4'hA);

        // R9 auto-EOI
        do_reset();
        aeoi_en = 1; aeoi_rot = 1;
        ack(3'd5);
        chk(isr_out == 0, "R9 no isr", isr_out, 0);
        chk(rot_out == 6, "R9 rotate", rot_out, 6);
        ack_line = 3'd7; ack_valid = 1; rot_val = 3'd2; rot_wr = 1;
        @(negedge clk); ack_valid = 0; rot_wr = 0;
        chk(rot_out == 0, "R9 beats load", rot_out, 0);
        aeoi_rot = 0;
        ack(3'd2);
        chk(rot_out == 0 && isr_out == 0, "R9 no rotate", rot_out, 0);

        // R11 fresh edge and ack together on edge line 4
        do_reset();
        irq_in = 8'h10;
        @(negedge clk); @(negedge clk);   // synchronized edge captured at next edge
        ack_line = 3'd4; ack_valid = 1;
        @(negedge clk); ack_valid = 0;
        chk(req_out[4] == 1, "R11 edge wins", req_out, 8'h10);
        chk(isr_out == 8'h10, "R11 isr", isr_out, 8'h10);
        ack(3'd4);
        chk(req_out[4] == 0, "R11 plain ack clears", req_out, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule